// File: doc/BRIEF.md
# Bus Access Error Detector

The block observes every transaction issued by the processor or the DMA master and checks it for five illegal conditions. Each condition has its own bit in a status register. A bit stays set until software writes a 1 to that bit position. Each access that trips one or more checks also produces a single-cycle error pulse. The block only watches. It does not stall or cancel the offending access, and it raises no interrupt.

An access is presented for one cycle with `acc_valid` high. All results are registered on that same clock edge, so the status bits and the pulse show up one cycle after the access is presented. The checks are listed below, with the lowest-numbered status bit first:

- A read from the inter-processor data buffer window.
- An opcode fetch from the peripheral space.
- A sub-word access to the peripheral space.
- A misaligned half-word or word access.
- Any access to the network MAC register window while the PHY clocks are stopped.

Top module: `bus_fault_monitor`

## Requirements
- R1: After reset, `status_q` is 0 and `err_pulse` is 0.
- R2: An access whose address lies in 0xE0010800..0xE001FFFF sets status bit 15 when `phy_clk_on` is 0. The same access sets no bit when `phy_clk_on` is 1.
- R3: A word access with address bits [1:0] not equal to 0, or a half-word access with address bit 0 set, sets status bit 13. A byte access never sets bit 13. The size encoding is 0 = byte, 1 = half-word, 2 = word, 3 = treated as word.
- R4: A byte or half-word access with an address in 0xE0000000..0xEFFFFFFF sets status bit 12. A word access there does not.
- R5: An access with `acc_fetch` = 1 and an address in 0xE0000000..0xEFFFFFFF sets status bit 10.
- R6: A read (`acc_write` = 0) with an address in 0xE0040000..0xE00407FF sets status bit 9. A write to that window sets no bit.
- R7: Status bits are sticky. A cycle with `clr_we` = 1 clears every bit that has a 1 at its position in `clr_mask`. Bits with a 0 in the mask are unchanged.
- R8: If an error and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: When one access trips several checks, all the matching bits are set on the same clock edge.
- R10: `err_pulse` is high for exactly one cycle, in the cycle after each access that trips at least one check. It stays low otherwise.
- R11: Status bits 0..8, 11 and 14 always read 0. Address, size and flag inputs have no effect while `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | 1 = opcode fetch |
| phy_clk_on | input | 1 | 1 = PHY clocks are running |
| clr_we | input | 1 | Apply the write-one-to-clear mask this cycle |
| clr_mask | input | 16 | Bits to clear |
| status_q | output | 16 | Sticky error status |
| err_pulse | output | 1 | One-cycle pulse after a faulting access |

## Verification
The hardest state to reach is a clear and a new error landing on the same bit in the same cycle. The bench gets there by first making a bit sticky with one faulting access. It then issues a second access that trips the same check while asserting `clr_we` with a full mask in that same cycle. Reaching several bits from one access needs addresses that fall inside nested windows. For example, a byte read in the data buffer window trips both the sub-word check and the buffer-read check, and a misaligned fetch from peripheral space trips both the alignment check and the fetch check.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   localparam int NUM_RULES = 5;
   typedef enum int {
      RULE_BUF  = 0,
      RULE_CODE = 1,
      RULE_SUB  = 2,
      RULE_ALGN = 3,
      RULE_MAC  = 4
   } rule_e;
endpackage

// File: rtl/bfm_window.sv
module bfm_window #(
   parameter int          AW = 32,
   parameter logic [AW-1:0] LO = '0,
   parameter logic [AW-1:0] HI = '1
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   if (LO > HI) begin : g_bad
      $error("bfm_window: LO above HI");
   end
   always_comb hit = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/bfm_rules.sv
module bfm_rules #(
   parameter int          AW       = 32,
   parameter logic [AW-1:0] PER_LO = 32'hE000_0000,
   parameter logic [AW-1:0] PER_HI = 32'hEFFF_FFFF,
   parameter logic [AW-1:0] MAC_LO = 32'hE001_0800,
   parameter logic [AW-1:0] MAC_HI = 32'hE001_FFFF,
   parameter logic [AW-1:0] BUF_LO = 32'hE004_0000,
   parameter logic [AW-1:0] BUF_HI = 32'hE004_07FF
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         valid,
   input  logic [AW-1:0]                addr,
   input  logic [1:0]                   size,
   input  logic                         write,
   input  logic                         fetch,
   input  logic                         phy_on,
   output logic [bfm_pkg::NUM_RULES-1:0] fault
);
   import bfm_pkg::*;
   localparam int NWIN = 3;
   localparam logic [NWIN-1:0][AW-1:0] WLO = {BUF_LO, MAC_LO, PER_LO};
   localparam logic [NWIN-1:0][AW-1:0] WHI = {BUF_HI, MAC_HI, PER_HI};

   logic [NWIN-1:0] win;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      bfm_window #(.AW(AW), .LO(WLO[w]), .HI(WHI[w])) u_win (
         .addr (addr),
         .hit  (win[w])
      );
   end

   logic is_sub, misal;
   always_comb begin
      is_sub = (size == SZ_BYTE) || (size == SZ_HALF);
      unique case (size)
         SZ_BYTE: misal = 1'b0;
         SZ_HALF: misal = addr[0];
         default: misal = |addr[1:0];
      endcase
      fault            = '0;
      fault[RULE_MAC]  = valid && win[1] && !phy_on;
      fault[RULE_ALGN] = valid && misal;
      fault[RULE_SUB]  = valid && win[0] && is_sub;
      fault[RULE_CODE] = valid && win[0] && fetch;
      fault[RULE_BUF]  = valid && win[2] && !write;
   end

   AST_BUF_WRITE_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (write |-> !fault[RULE_BUF])); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid |-> fault == '0)); // R11
   AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (size == SZ_BYTE |-> !fault[RULE_ALGN])); // R3
endmodule

// File: rtl/bfm_status.sv
module bfm_status #(
   parameter int          SW   = 16,
   parameter int          NR   = 5,
   parameter int          POS [NR] = '{9, 10, 12, 13, 15}
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NR-1:0] fault,
   input  logic          clr_we,
   input  logic [SW-1:0] clr_mask,
   output logic [SW-1:0] status_q,
   output logic          pulse_q
);
   logic [SW-1:0] set_vec;

   always_comb begin
      set_vec = '0;
      for (int r = 0; r < NR; r++) set_vec[POS[r]] = fault[r];
   end

   for (genvar r = 0; r < NR; r++) begin : g_chk
      if (POS[r] >= SW) begin : g_range
         $error("bfm_status: bit position outside register");
      end
      for (genvar k = r + 1; k < NR; k++) begin : g_dup
         if (POS[r] == POS[k]) begin : g_clash
            $error("bfm_status: two rules share a bit");
         end
      end
   end

   for (genvar b = 0; b < SW; b++) begin : g_bit
      logic used;
      always_comb begin
         used = 1'b0;
         for (int r = 0; r < NR; r++) if (POS[r] == b) used = 1'b1;
      end
      if (1) begin : g_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       status_q[b] <= 1'b0;
            else if (used && set_vec[b])      status_q[b] <= 1'b1;
            else if (clr_we && clr_mask[b])   status_q[b] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= |fault;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0 |=> (status_q & $past(set_vec)) == $past(set_vec))); // R8
   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (1'b1 |=> (status_q & ~$past(status_q) & ~$past(set_vec)) == '0)); // R7
   AST_PULSE_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q |-> status_q != '0)); // R10
endmodule

// File: rtl/bus_fault_monitor.sv
module bus_fault_monitor #(
   parameter int AW = 32,
   parameter int SW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_valid,
   input  logic [31:0]   acc_addr,
   input  logic [1:0]    acc_size,
   input  logic          acc_write,
   input  logic          acc_fetch,
   input  logic          phy_clk_on,
   input  logic          clr_we,
   input  logic [15:0]   clr_mask,
   output logic [15:0]   status_q,
   output logic          err_pulse
);
   import bfm_pkg::*;
   if (AW != 32 || SW != 16) begin : g_cfg
      $error("bus_fault_monitor: port widths are fixed at 32/16");
   end

   localparam int BIT_POS [NUM_RULES] = '{9, 10, 12, 13, 15};
   localparam logic [SW-1:0] USED = 16'hB600;

   logic [NUM_RULES-1:0] fault;

   bfm_rules #(.AW(AW)) u_rules (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (acc_valid),
      .addr   (acc_addr),
      .size   (acc_size),
      .write  (acc_write),
      .fetch  (acc_fetch),
      .phy_on (phy_clk_on),
      .fault  (fault)
   );

   bfm_status #(.SW(SW), .NR(NUM_RULES), .POS(BIT_POS)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .fault    (fault),
      .clr_we   (clr_we),
      .clr_mask (clr_mask),
      .status_q (status_q),
      .pulse_q  (err_pulse)
   );

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~USED) == '0)); // R11
   AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_pulse && !$past(acc_valid) |=> 1'b0 || !err_pulse)); // R10
   AST_PULSE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid |=> !err_pulse)); // R10
endmodule

// File: tb/bus_fault_monitor_bench.sv
module bus_fault_monitor_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_size = '0;
   logic        acc_write = 1'b0;
   logic        acc_fetch = 1'b0;
   logic        phy_clk_on = 1'b1;
   logic        clr_we = 1'b0;
   logic [15:0] clr_mask = '0;
   logic [15:0] status_q;
   logic        err_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bus_fault_monitor u_bus_fault_monitor (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      @(negedge clk); clr_we = 1'b1; clr_mask = 16'hFFFF;
      @(negedge clk); clr_we = 1'b0; clr_mask = '0;
   endtask

   // Present one access, then sample status and pulse in the following cycle.
   task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                         input logic fe, input logic phy,
                         input string req, input logic [15:0] exp_st);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_size = sz;
      acc_write = wr; acc_fetch = fe; phy_clk_on = phy;
      @(negedge clk);
      acc_valid = 1'b0; phy_clk_on = 1'b1;
      check(req, status_q, exp_st);
      check({req, " pulse"}, err_pulse, exp_st != 0);
      @(negedge clk);
      check({req, " pulse single"}, err_pulse, 1'b0);
      clear_all();
   endtask

   task automatic t_reset();
      check("R1 status", status_q, 16'h0);
      check("R1 pulse", err_pulse, 1'b0);
   endtask

   task automatic t_single();
      access(32'hE001_0800, 2'd2, 1'b0, 1'b0, 1'b0, "R2 mac low edge", 16'h8000);
      access(32'hE001_FFFC, 2'd2, 1'b1, 1'b0, 1'b0, "R2 mac high", 16'h8000);
      access(32'hE001_0800, 2'd2, 1'b0, 1'b0, 1'b1, "R2 phy on", 16'h0000);
      access(32'hE001_07FC, 2'd2, 1'b0, 1'b0, 1'b0, "R2 below window", 16'h0000);
      access(32'h0000_0002, 2'd2, 1'b0, 1'b0, 1'b1, "R3 word misaligned", 16'h2000);
      access(32'h0000_0001, 2'd1, 1'b1, 1'b0, 1'b1, "R3 half odd", 16'h2000);
      access(32'h0000_0002, 2'd1, 1'b0, 1'b0, 1'b1, "R3 half even", 16'h0000);
      access(32'h0000_0003, 2'd0, 1'b0, 1'b0, 1'b1, "R3 byte", 16'h0000);
      access(32'hE000_0000, 2'd0, 1'b1, 1'b0, 1'b1, "R4 byte periph", 16'h1000);
      access(32'hEFFF_FFFE, 2'd1, 1'b0, 1'b0, 1'b1, "R4 half periph top", 16'h1000);
      access(32'hF000_0000, 2'd0, 1'b0, 1'b0, 1'b1, "R4 above periph", 16'h0000);
      access(32'hE000_0100, 2'd2, 1'b0, 1'b0, 1'b1, "R4 word periph", 16'h0000);
      access(32'hE100_0000, 2'd2, 1'b0, 1'b1, 1'b1, "R5 fetch periph", 16'h0400);
      access(32'h0000_1000, 2'd2, 1'b0, 1'b1, 1'b1, "R5 fetch ram", 16'h0000);
      access(32'hE004_07FC, 2'd2, 1'b0, 1'b0, 1'b1, "R6 buf read", 16'h0200);
      access(32'hE004_0000, 2'd2, 1'b1, 1'b0, 1'b1, "R6 buf write", 16'h0000);
   endtask

   task automatic t_multi();
      access(32'hE004_0001, 2'd0, 1'b0, 1'b0, 1'b1, "R9 byte buf read", 16'h1200);
      access(32'hE000_0002, 2'd2, 1'b0, 1'b1, 1'b1, "R9 misaligned fetch", 16'h2400);
      access(32'hE001_0801, 2'd1, 1'b0, 1'b1, 1'b0, "R9 four bits", 16'hB400);
   endtask

   task automatic t_sticky();
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = 32'h3; acc_size = 2'd2; acc_fetch = 1'b0; acc_write = 1'b0;
      @(negedge clk);
      acc_addr = 32'hE004_0000; acc_size = 2'd2;
      @(negedge clk);
      acc_valid = 1'b0;
      check("R7 both sticky", status_q, 16'h2200);
      check("R10 pulse on 2nd access", err_pulse, 1'b1);
      // accesses ignored while valid low
      @(negedge clk); acc_addr = 32'hE001_0800; phy_clk_on = 1'b0; acc_fetch = 1'b1; acc_size = 2'd0;
      @(negedge clk); phy_clk_on = 1'b1; acc_fetch = 1'b0;
      check("R11 idle ignored", status_q, 16'h2200);
      check("R11 idle no pulse", err_pulse, 1'b0);
      clr_we = 1'b1; clr_mask = 16'h0200;
      @(negedge clk); clr_we = 1'b0; clr_mask = '0;
      check("R7 partial clear", status_q, 16'h2000);
      clr_we = 1'b1; clr_mask = 16'h4DFF;
      @(negedge clk); clr_we = 1'b0; clr_mask = '0;
      check("R7 clear other bits", status_q, 16'h2000);
      // new alignment error in the same cycle as a full clear
      acc_valid = 1'b1; acc_addr = 32'h1; acc_size = 2'd2;
      clr_we = 1'b1; clr_mask = 16'hFFFF;
      @(negedge clk);
      acc_valid = 1'b0; clr_we = 1'b0; clr_mask = '0;
      check("R8 set wins", status_q, 16'h2000);
      clear_all();
      check("R7 cleared", status_q, 16'h0);
   endtask

   task automatic t_unused();
      @(negedge clk); clr_we = 1'b1; clr_mask = 16'h0000;
      acc_valid = 1'b1; acc_addr = 32'hE004_0003; acc_size = 2'd3; acc_fetch = 1'b1; phy_clk_on = 1'b0;
      @(negedge clk);
      acc_valid = 1'b0; clr_we = 1'b0; acc_fetch = 1'b0; phy_clk_on = 1'b1;
      check("R11 unused bits zero", status_q & 16'h49FF, 16'h0);
      check("R3 size 3 as word", status_q[13], 1'b1);
      clear_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_multi();
      t_sticky();
      t_unused();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule